// File: doc/BRIEF.md
# Instruction Trace Capture Buffer

This block keeps a history of retired instructions in an on-chip circular memory so that a debugger can read it back after the program stops. Each record holds the program counter of the retired instruction. In full-record mode it also holds the accumulator and the value of one register picked by the debug logic. In compact mode only the program counter is kept, and two of them share one memory word, so the buffer holds twice as many instructions.

The debugger programs a trigger address, an optional inclusive address window and a full-buffer policy, then pulses arm. Arming latches the whole setup and empties the buffer. Capture begins with the first retired instruction whose program counter equals the trigger address. From then on, every retired instruction whose PC falls inside the window (or every one, with the window off) is recorded. When the buffer is full, the block either overwrites the oldest record or stops recording and raises a halt request for the CPU.

Readout uses a logical index where 0 is the oldest valid record. The block turns that index into a physical slot from its write pointer and its wrapped flag, and returns the record one cycle later.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, entry_count, wrapped and halt_req are 0, and retired instructions are not recorded until the first arm pulse.
- R2: After arming, no instruction is recorded until one retires with PC equal to the latched trigger address. That instruction is the first one eligible for recording.
- R3: With the window enabled, an instruction is recorded only when win_lo <= PC <= win_hi, both bounds inclusive. This also applies to the triggering instruction, which still starts capture when it lies outside the window.
- R4: In full-record mode (cfg_pc_only = 0) a record returns the PC, the accumulator and the selected register as they were presented at retire. Capacity is DEPTH records.
- R5: In compact mode (cfg_pc_only = 1) capacity is 2*DEPTH records, and rd_acc and rd_sel read as 0.
- R6: In overwrite mode (cfg_halt_full = 0), a record made while the buffer is full replaces the oldest record. entry_count rises by one per record and holds at capacity.
- R7: wrapped goes to 1 once capacity-many records have been written since arming, and stays 1 until the next arm.
- R8: In halt mode (cfg_halt_full = 1), halt_req goes to 1 in the cycle after the record that fills the buffer. Later retires are not recorded, and halt_req stays 1 until the next arm.
- R9: rd_idx = 0 selects the oldest valid record and higher indices select newer ones. rd_pc, rd_acc and rd_sel show the selected record one clock after rd_idx is presented.
- R10: Trigger, window, mode and policy are latched at the arm pulse. Changing the cfg inputs afterwards has no effect until the next arm.
- R11: An arm pulse clears entry_count, wrapped and halt_req by the next cycle. An instruction retired in the same cycle as the arm pulse is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | PC_W | PC of the retiring instruction |
| ret_acc | input | PC_W/2 | Accumulator value at retire |
| ret_sel | input | PC_W/2 | Value of the selected register at retire |
| cfg_arm | input | 1 | Arm pulse: latches the setup and empties the buffer |
| cfg_pc_only | input | 1 | 1 = compact PC-only records, 0 = full records |
| cfg_win_en | input | 1 | Enables address windowing |
| cfg_halt_full | input | 1 | 1 = halt when full, 0 = overwrite the oldest record |
| cfg_trig_pc | input | PC_W | Trigger address that starts capture |
| cfg_win_lo | input | PC_W | Lower window bound, inclusive |
| cfg_win_hi | input | PC_W | Upper window bound, inclusive |
| rd_idx | input | $clog2(2*DEPTH) | Logical read index, 0 = oldest record |
| rd_pc | output | PC_W | PC of the selected record |
| rd_acc | output | PC_W/2 | Accumulator of the selected record (0 in compact mode) |
| rd_sel | output | PC_W/2 | Selected register of the record (0 in compact mode) |
| entry_count | output | $clog2(2*DEPTH+1) | Number of valid records |
| wrapped | output | 1 | The write pointer has passed the end of the buffer |
| halt_req | output | 1 | Halt request raised when the buffer fills in halt mode |

## Verification
A retire or arm pulse driven before a clock edge shows up in entry_count, wrapped and halt_req right after that edge. The bench therefore drives these inputs on the falling edge and checks status on the next falling edge. Read data comes from a registered memory read, so it is due one edge after rd_idx changes. The read driver tags each expected record with the cycle number of that edge, and the monitor compares an item only when the cycle counter reaches its tag. A reference queue kept in the bench supplies the expected contents, count, wrap state and halt state, built from the trigger, window and full-buffer rules alone.

// File: rtl/trace_pkg.sv
package trace_pkg;

    // capture sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // never armed since reset
        ST_WAIT = 2'd1,   // armed, waiting for the trigger address
        ST_RUN  = 2'd2,   // recording
        ST_FULL = 2'd3    // halt-on-full reached, recording stopped
    } trc_state_e;

endpackage

// File: rtl/trace_filter.sv
module trace_filter #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] trig_pc,
    input  logic            win_en,
    input  logic [PC_W-1:0] win_lo,
    input  logic [PC_W-1:0] win_hi,
    output logic            trig_hit,
    output logic            in_window
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        trig_hit  = (pc == trig_pc);
        above_lo  = (pc >= win_lo);
        below_hi  = (pc <= win_hi);
        in_window = !win_en || (above_lo && below_hi);
    end

endmodule

// File: rtl/trace_store.sv
module trace_store #(
    parameter int DEPTH = 1000,
    parameter int HW    = 16,
    localparam int WA_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic [1:0]      we,        // [0] low half, [1] high half
    input  logic [WA_W-1:0] waddr,
    input  logic [HW-1:0]   wdata_lo,
    input  logic [HW-1:0]   wdata_hi,
    input  logic [WA_W-1:0] raddr,
    output logic [HW-1:0]   rdata_lo,
    output logic [HW-1:0]   rdata_hi
);

    logic [HW-1:0] wdata [2];
    logic [HW-1:0] rdata [2];

    always_comb begin
        wdata[0] = wdata_lo;
        wdata[1] = wdata_hi;
        rdata_lo = rdata[0];
        rdata_hi = rdata[1];
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [HW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[b]) begin
                mem[waddr] <= wdata[b];
            end
            rdata[b] <= mem[raddr];
        end
    end

endmodule

// File: rtl/trace_rdmap.sv
module trace_rdmap #(
    parameter int DEPTH = 1000,
    localparam int ENT_W = $clog2(2*DEPTH),
    localparam int WA_W  = $clog2(DEPTH)
) (
    input  logic [ENT_W-1:0] oldest,
    input  logic [ENT_W-1:0] idx,
    input  logic [ENT_W:0]   cap,
    input  logic             pc_only,
    output logic [WA_W-1:0]  word_addr,
    output logic             half
);

    logic [ENT_W:0]   sum;
    logic [ENT_W:0]   slot_w;
    logic [ENT_W-1:0] slot;

    always_comb begin
        sum    = {1'b0, oldest} + {1'b0, idx};
        slot_w = (sum >= cap) ? (sum - cap) : sum;
        slot   = slot_w[ENT_W-1:0];
        if (pc_only) begin
            word_addr = slot[ENT_W-1:1];
            half      = slot[0];
        end else begin
            word_addr = slot[WA_W-1:0];
            half      = 1'b0;
        end
    end

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
    parameter int PC_W  = 16,
    parameter int DEPTH = 1000,
    localparam int DW    = PC_W / 2,
    localparam int ENT_W = $clog2(2*DEPTH),
    localparam int CNT_W = $clog2(2*DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ret_valid,
    input  logic [PC_W-1:0]  ret_pc,
    input  logic [DW-1:0]    ret_acc,
    input  logic [DW-1:0]    ret_sel,
    input  logic             cfg_arm,
    input  logic             cfg_pc_only,
    input  logic             cfg_win_en,
    input  logic             cfg_halt_full,
    input  logic [PC_W-1:0]  cfg_trig_pc,
    input  logic [PC_W-1:0]  cfg_win_lo,
    input  logic [PC_W-1:0]  cfg_win_hi,
    input  logic [ENT_W-1:0] rd_idx,
    output logic [PC_W-1:0]  rd_pc,
    output logic [DW-1:0]    rd_acc,
    output logic [DW-1:0]    rd_sel,
    output logic [CNT_W-1:0] entry_count,
    output logic             wrapped,
    output logic             halt_req
);

    import trace_pkg::*;

    localparam int WA_W = $clog2(DEPTH);
    localparam logic [ENT_W:0]   CAP_FULL_E = (ENT_W+1)'(DEPTH);
    localparam logic [ENT_W:0]   CAP_PC_E   = (ENT_W+1)'(2*DEPTH);
    localparam logic [ENT_W-1:0] LAST_FULL  = ENT_W'(DEPTH-1);
    localparam logic [ENT_W-1:0] LAST_PC    = ENT_W'(2*DEPTH-1);
    localparam logic [CNT_W-1:0] CAP_FULL_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_PC_C   = CNT_W'(2*DEPTH);

    typedef struct packed {
        trc_state_e       st;
        logic             pc_only;
        logic             win_en;
        logic             halt_mode;
        logic [PC_W-1:0]  trig;
        logic [PC_W-1:0]  lo;
        logic [PC_W-1:0]  hi;
        logic [ENT_W-1:0] wptr;
        logic [CNT_W-1:0] count;
        logic             wrapped;
        logic             halt;
        logic             rd_half;
        logic             rd_pconly;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // filter results on the latched setup
    logic trig_hit;
    logic in_window;

    // memory side
    logic [1:0]      mem_we;
    logic [WA_W-1:0] mem_waddr;
    logic [PC_W-1:0] mem_wlo;
    logic [WA_W-1:0] mem_raddr;
    logic [PC_W-1:0] mem_rlo;
    logic [PC_W-1:0] mem_rhi;

    // read mapping
    logic [ENT_W-1:0] oldest;
    logic [ENT_W:0]   cap_e;
    logic             rd_half_sel;

    // sequencer helpers
    logic [ENT_W-1:0] last_slot;
    logic [CNT_W-1:0] cap_c;
    logic             record;

    trace_filter #(
        .PC_W (PC_W)
    ) i_filter (
        .pc        (ret_pc),
        .trig_pc   (ctl_q.trig),
        .win_en    (ctl_q.win_en),
        .win_lo    (ctl_q.lo),
        .win_hi    (ctl_q.hi),
        .trig_hit  (trig_hit),
        .in_window (in_window)
    );

    trace_store #(
        .DEPTH (DEPTH),
        .HW    (PC_W)
    ) i_store (
        .clk      (clk),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wdata_lo (mem_wlo),
        .wdata_hi (ret_pc),
        .raddr    (mem_raddr),
        .rdata_lo (mem_rlo),
        .rdata_hi (mem_rhi)
    );

    trace_rdmap #(
        .DEPTH (DEPTH)
    ) i_rdmap (
        .oldest    (oldest),
        .idx       (rd_idx),
        .cap       (cap_e),
        .pc_only   (ctl_q.pc_only),
        .word_addr (mem_raddr),
        .half      (rd_half_sel)
    );

    // next-state computation
    always_comb begin
        ctl_d     = ctl_q;
        record    = 1'b0;
        last_slot = ctl_q.pc_only ? LAST_PC   : LAST_FULL;
        cap_c     = ctl_q.pc_only ? CAP_PC_C  : CAP_FULL_C;
        cap_e     = ctl_q.pc_only ? CAP_PC_E  : CAP_FULL_E;
        oldest    = ctl_q.wrapped ? ctl_q.wptr : '0;

        if (cfg_arm) begin
            ctl_d.st        = ST_WAIT;
            ctl_d.pc_only   = cfg_pc_only;
            ctl_d.win_en    = cfg_win_en;
            ctl_d.halt_mode = cfg_halt_full;
            ctl_d.trig      = cfg_trig_pc;
            ctl_d.lo        = cfg_win_lo;
            ctl_d.hi        = cfg_win_hi;
            ctl_d.wptr      = '0;
            ctl_d.count     = '0;
            ctl_d.wrapped   = 1'b0;
            ctl_d.halt      = 1'b0;
        end else if (ret_valid) begin
            unique case (ctl_q.st)
                ST_WAIT: begin
                    if (trig_hit) begin
                        ctl_d.st = ST_RUN;
                        record   = in_window;
                    end
                end
                ST_RUN:  record = in_window;
                default: record = 1'b0;
            endcase

            if (record) begin
                if (ctl_q.wptr == last_slot) begin
                    ctl_d.wptr    = '0;
                    ctl_d.wrapped = 1'b1;
                end else begin
                    ctl_d.wptr = ctl_q.wptr + 1'b1;
                end
                if (ctl_q.count != cap_c) begin
                    ctl_d.count = ctl_q.count + 1'b1;
                end
                if (ctl_q.halt_mode && (ctl_q.count == cap_c - 1'b1)) begin
                    ctl_d.st   = ST_FULL;
                    ctl_d.halt = 1'b1;
                end
            end
        end

        // read pipeline bookkeeping, aligned with the registered memory read
        ctl_d.rd_half   = rd_half_sel;
        ctl_d.rd_pconly = ctl_q.pc_only;
    end

    // write port: compact mode fills one half per record
    always_comb begin
        mem_we[0] = record && (!ctl_q.pc_only || !ctl_q.wptr[0]);
        mem_we[1] = record && (!ctl_q.pc_only ||  ctl_q.wptr[0]);
        mem_wlo   = ctl_q.pc_only ? ret_pc : {ret_acc, ret_sel};
        mem_waddr = ctl_q.pc_only ? ctl_q.wptr[ENT_W-1:1] : ctl_q.wptr[WA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // output formatting
    always_comb begin
        if (ctl_q.rd_pconly) begin
            rd_pc  = ctl_q.rd_half ? mem_rhi : mem_rlo;
            rd_acc = '0;
            rd_sel = '0;
        end else begin
            rd_pc  = mem_rhi;
            rd_acc = mem_rlo[PC_W-1:DW];
            rd_sel = mem_rlo[DW-1:0];
        end
        entry_count = ctl_q.count;
        wrapped     = ctl_q.wrapped;
        halt_req    = ctl_q.halt;
    end

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
    parameter int DEPTH = 1000,
    localparam int CNT_W = $clog2(2*DEPTH+1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ret_valid,
    input logic             cfg_arm,
    input logic [CNT_W-1:0] entry_count,
    input logic             wrapped,
    input logic             halt_req
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(2*DEPTH);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CNT_MAX);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_arm |=> (entry_count == $past(entry_count)) ||
                     (entry_count == $past(entry_count) + 1'b1));

    // R1
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_valid && !cfg_arm) |=> $stable(entry_count));

    // R7
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !cfg_arm) |=> wrapped);

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !cfg_arm) |=> halt_req && $stable(entry_count));

    // R11
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_arm |=> (entry_count == '0) && !wrapped && !halt_req);

endmodule

bind trace_capture_buf trace_capture_chk #(
    .DEPTH (DEPTH)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_valid   (ret_valid),
    .cfg_arm     (cfg_arm),
    .entry_count (entry_count),
    .wrapped     (wrapped),
    .halt_req    (halt_req)
);

// File: tb/test_trace_capture_buf.sv
`timescale 1ns/1ps
module test_trace_capture_buf;

    localparam int PC_W  = 16;
    localparam int DEPTH = 5;
    localparam int DW    = PC_W / 2;
    localparam int ENT_W = $clog2(2*DEPTH);
    localparam int CNT_W = $clog2(2*DEPTH+1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ret_valid = 1'b0;
    logic [PC_W-1:0]  ret_pc = '0;
    logic [DW-1:0]    ret_acc = '0;
    logic [DW-1:0]    ret_sel = '0;
    logic             cfg_arm = 1'b0;
    logic             cfg_pc_only = 1'b0;
    logic             cfg_win_en = 1'b0;
    logic             cfg_halt_full = 1'b0;
    logic [PC_W-1:0]  cfg_trig_pc = '0;
    logic [PC_W-1:0]  cfg_win_lo = '0;
    logic [PC_W-1:0]  cfg_win_hi = '0;
    logic [ENT_W-1:0] rd_idx = '0;
    logic [PC_W-1:0]  rd_pc;
    logic [DW-1:0]    rd_acc;
    logic [DW-1:0]    rd_sel;
    logic [CNT_W-1:0] entry_count;
    logic             wrapped;
    logic             halt_req;

    always #2 clk = ~clk;   // 250 MHz

    trace_capture_buf #(
        .PC_W  (PC_W),
        .DEPTH (DEPTH)
    ) i_trace_capture_buf (
        .clk           (clk),
        .rst_n         (rst_n),
        .ret_valid     (ret_valid),
        .ret_pc        (ret_pc),
        .ret_acc       (ret_acc),
        .ret_sel       (ret_sel),
        .cfg_arm       (cfg_arm),
        .cfg_pc_only   (cfg_pc_only),
        .cfg_win_en    (cfg_win_en),
        .cfg_halt_full (cfg_halt_full),
        .cfg_trig_pc   (cfg_trig_pc),
        .cfg_win_lo    (cfg_win_lo),
        .cfg_win_hi    (cfg_win_hi),
        .rd_idx        (rd_idx),
        .rd_pc         (rd_pc),
        .rd_acc        (rd_acc),
        .rd_sel        (rd_sel),
        .entry_count   (entry_count),
        .wrapped       (wrapped),
        .halt_req      (halt_req)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // reference model
    typedef struct {
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   sel;
    } ent_t;

    typedef struct {
        int              due;
        int              idx;
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   acc;
        logic [DW-1:0]   sel;
        string           req;
    } exp_t;

    ent_t mdl[$];
    exp_t sb[$];
    int   m_state = 0;       // 0 idle, 1 waiting, 2 running, 3 halted
    int   m_writes = 0;
    bit   m_pconly, m_win, m_halt;
    logic [PC_W-1:0] m_trig, m_lo, m_hi;

    function automatic int m_cap();
        return m_pconly ? 2*DEPTH : DEPTH;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_status(input string req);
        check(req, "entry_count", int'(entry_count), mdl.size());
        check(req, "wrapped", int'(wrapped), (m_writes >= m_cap()) ? 1 : 0);
        check(req, "halt_req", int'(halt_req), (m_state == 3) ? 1 : 0);
    endtask

    task automatic retire(input logic [PC_W-1:0] pc, input logic [DW-1:0] acc,
                          input logic [DW-1:0] sel);
        bit rec;
        @(negedge clk);
        ret_valid = 1'b1; ret_pc = pc; ret_acc = acc; ret_sel = sel;
        @(negedge clk);
        ret_valid = 1'b0;
        rec = 1'b0;
        if (m_state == 1 && pc == m_trig) m_state = 2;
        if (m_state == 2 && (!m_win || (pc >= m_lo && pc <= m_hi))) rec = 1'b1;
        if (rec) begin
            ent_t e;
            e.pc = pc;
            e.acc = m_pconly ? '0 : acc;
            e.sel = m_pconly ? '0 : sel;
            mdl.push_back(e);
            m_writes++;
            if (mdl.size() > m_cap()) void'(mdl.pop_front());
            if (m_halt && mdl.size() == m_cap()) m_state = 3;
        end
    endtask

    task automatic arm(input bit pconly, input bit win, input bit halt,
                       input logic [PC_W-1:0] trig, input logic [PC_W-1:0] lo,
                       input logic [PC_W-1:0] hi, input bit with_retire);
        @(negedge clk);
        cfg_arm = 1'b1; cfg_pc_only = pconly; cfg_win_en = win; cfg_halt_full = halt;
        cfg_trig_pc = trig; cfg_win_lo = lo; cfg_win_hi = hi;
        if (with_retire) begin
            ret_valid = 1'b1; ret_pc = trig; ret_acc = 8'h5A; ret_sel = 8'hA5;
        end
        @(negedge clk);
        cfg_arm = 1'b0; ret_valid = 1'b0;
        mdl.delete();
        m_state = 1; m_writes = 0;
        m_pconly = pconly; m_win = win; m_halt = halt;
        m_trig = trig; m_lo = lo; m_hi = hi;
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < mdl.size(); i++) begin
            exp_t x;
            @(negedge clk);
            rd_idx = ENT_W'(i);
            x.due = cyc + 1; x.idx = i;
            x.pc = mdl[i].pc; x.acc = mdl[i].acc; x.sel = mdl[i].sel; x.req = req;
            sb.push_back(x);
        end
        repeat (3) @(negedge clk);
    endtask

    // monitor: compares one cycle after each read index was driven
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t x;
            x = sb.pop_front();
            checks++;
            if (rd_pc !== x.pc || rd_acc !== x.acc || rd_sel !== x.sel) begin
                errors++;
                $display("FAIL %s read idx %0d: actual %h/%h/%h expected %h/%h/%h",
                         x.req, x.idx, rd_pc, rd_acc, rd_sel, x.pc, x.acc, x.sel);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, retires ignored before arming
        check_status("R1");
        retire(16'h0100, 8'h11, 8'h22);
        retire(16'h0104, 8'h11, 8'h22);
        check("R1", "count unarmed", int'(entry_count), 0);

        // R2 / R4 / R9: trigger then full records
        arm(1'b0, 1'b0, 1'b0, 16'h0100, '0, '0, 1'b0);
        retire(16'h00F0, 8'h01, 8'h02);
        retire(16'h00F4, 8'h03, 8'h04);
        check("R2", "count before trigger", int'(entry_count), 0);
        retire(16'h0100, 8'h10, 8'h20);
        retire(16'h0102, 8'h11, 8'h21);
        retire(16'h0105, 8'h12, 8'h22);
        retire(16'h0100, 8'h13, 8'h23);
        check_status("R2");
        read_all("R4");

        // R6 / R7 / R9: overwrite wrap with non power-of-two depth
        for (int i = 0; i < 8; i++) retire(16'h0200 + 16'(i), 8'(8'h40 + i), 8'(8'h80 + i));
        check_status("R6");
        check("R7", "wrapped", int'(wrapped), 1);
        read_all("R9");

        // R3: inclusive window, trigger outside window
        arm(1'b0, 1'b1, 1'b0, 16'h01F0, 16'h0200, 16'h020F, 1'b0);
        retire(16'h01F0, 8'h01, 8'h01);
        retire(16'h01FF, 8'h02, 8'h02);
        retire(16'h0200, 8'h03, 8'h03);
        retire(16'h0208, 8'h04, 8'h04);
        retire(16'h020F, 8'h05, 8'h05);
        retire(16'h0210, 8'h06, 8'h06);
        check_status("R3");
        check("R3", "window count", int'(entry_count), 3);
        read_all("R3");

        // R5: compact mode doubles capacity, acc/sel read zero
        arm(1'b1, 1'b0, 1'b0, 16'h0300, '0, '0, 1'b0);
        for (int i = 0; i < 13; i++) retire(16'h0300 + 16'(2*i), 8'hEE, 8'hDD);
        check_status("R5");
        check("R5", "compact capacity", int'(entry_count), 2*DEPTH);
        read_all("R5");

        // R8 / R10: halt on full, setup changed after arm ignored
        arm(1'b0, 1'b0, 1'b1, 16'h0400, '0, '0, 1'b0);
        @(negedge clk);
        cfg_halt_full = 1'b0; cfg_pc_only = 1'b1; cfg_trig_pc = 16'h0999;
        for (int i = 0; i < 4; i++) retire(16'h0400 + 16'(i), 8'(i), 8'(8'hF0 + i));
        check("R8", "halt before full", int'(halt_req), 0);
        retire(16'h0404, 8'h04, 8'hF4);
        check("R8", "halt after full", int'(halt_req), 1);
        check("R10", "capacity kept", int'(entry_count), DEPTH);
        retire(16'h0405, 8'h05, 8'hF5);
        retire(16'h0406, 8'h06, 8'hF6);
        check_status("R8");
        read_all("R8");

        // R11: arm clears state, same-cycle retire ignored
        arm(1'b0, 1'b0, 1'b0, 16'h0500, '0, '0, 1'b1);
        check_status("R11");
        retire(16'h0500, 8'h77, 8'h88);
        check("R11", "first record after arm", int'(entry_count), 1);
        read_all("R11");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule